// File: doc/BRIEF.md
# DRAM Sleep Width Guard

This block drives the deep-sleep output that removes power from system memory. A request input asks for the output to assert or release. The block guarantees that, once asserted, the output stays on long enough for the memory devices to fully lose and regain power. It runs from the slow always-on clock, and its configuration survives every reset except the always-on well reset.

A small register holds three fields. The first is a width code that selects a coarse minimum hold window measured in whole seconds. The second is a stretch enable. With stretch enabled, an early release request is held off until the window has passed. With stretch disabled, the output follows the request one slow cycle later, and an early release is only recorded. The third field is a sticky violation flag that firmware reads after the system is running again. A free-running prescaler turns slow-clock cycles into one-second ticks. The window counts whole ticks after assertion, so each code covers a one-second range.

Top module: `dram_sleep_guard`

## Requirements
- R1: When the output is low and the request is seen high at a clock edge, the output is high after that edge. With stretch disabled, a request that is high for exactly one cycle gives an output pulse of exactly one cycle.
- R2: The well reset `rst_n` is active low and is sampled on `clk`. While it is low, the output, width code, stretch enable and violation flag all clear, so the width code becomes 00 (the longest window).
- R3: The register layout is as follows. Bits [1:0] hold the width code, bit 2 holds the stretch enable and bit 3 holds the violation flag. A write loads bits [1:0] and bit 2 from `cfg_wdata`, and `cfg_rdata` returns all four bits.
- R4: The width code selects a window of N = 5 - code ticks, so code 11 gives N = 2 and code 00 gives N = 5. One tick lasts TICKS_PER_SEC cycles. With stretch enabled and a one-cycle request, the assertion lasts D cycles, where (N-1)*TICKS_PER_SEC+2 <= D <= N*TICKS_PER_SEC+1. For code 11 this is 1 to 2 seconds, and for code 00 it is 4 to 5 seconds.
- R5: With stretch enabled, a release request that arrives before the window has elapsed is ignored. The output falls on the first clock edge after the window expires.
- R6: If the window has already elapsed, or stretch is disabled, the output falls on the edge that sees the request low. A request held high for L cycles then gives exactly L cycles of output.
- R7: The violation flag sets when an assertion ends before its window has elapsed. It stays set through later assertions that end correctly.
- R8: A write with bit 3 = 1 clears the violation flag. A write with bit 3 = 0 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Always-on well reset, active low, sampled on clk |
| sleep_req | input | 1 | 1 requests the deep-sleep output asserted |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | CODE_W+2 | Write data: code, stretch enable, violation clear |
| cfg_rdata | output | CODE_W+2 | Read data: code, stretch enable, violation flag |
| sleep_out | output | 1 | Deep-sleep output, 1 = asserted |

## Verification
The assertions assume that `rst_n` is held low across at least one rising clock edge from time zero. They also assume that the request and the register write strobe change only between clock edges. They do not assume any particular request length, because the hold window has to cope with any release timing. The stimulus drives every input on the falling clock edge and holds reset for two full cycles. It uses a short tick count, so that every window code can be measured against its cycle bounds.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
   // Register field positions, derived from the code width
   function automatic int stretch_bit(input int code_w);
      return code_w;
   endfunction

   function automatic int viol_bit(input int code_w);
      return code_w + 1;
   endfunction

   // Tick count of the longest window (code all zeros)
   function automatic int max_ticks(input int code_w);
      return (1 << code_w) + 1;
   endfunction
endpackage

// File: rtl/dsg_tick_gen.sv
module dsg_tick_gen #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICKS_PER_SEC == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int PW = $clog2(TICKS_PER_SEC);
         localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n)        pre_q <= '0;
            else if (tick)     pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/dsg_cfg_reg.sv
module dsg_cfg_reg #(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CODE_W+1:0] wdata,
   input  logic              viol_set,
   output logic [CODE_W-1:0] code_q,
   output logic              stretch_q,
   output logic              viol_q
);
   import dsg_pkg::*;
   localparam int SB = stretch_bit(CODE_W);
   localparam int VB = viol_bit(CODE_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q    <= '0;
         stretch_q <= 1'b0;
         viol_q    <= 1'b0;
      end else begin
         if (wr) begin
            code_q    <= wdata[CODE_W-1:0];
            stretch_q <= wdata[SB];
         end
         if (viol_set)                viol_q <= 1'b1;
         else if (wr && wdata[VB])    viol_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dsg_window.sv
module dsg_window #(
   parameter int CODE_W = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   input  logic              stretch,
   output logic              out_q,
   output logic              win_done,
   output logic              viol_set,
   output logic [CNT_W-1:0]  tick_cnt
);
   import dsg_pkg::*;
   localparam int MAXT = max_ticks(CODE_W);
   localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAXT);

   logic [CNT_W-1:0] need;
   logic             hold;
   logic             out_d;

   always_comb begin
      need     = MAXC - CNT_W'(code);
      win_done = (tick_cnt >= need);
      hold     = out_q && stretch && !win_done;
      out_d    = out_q ? (req || hold) : req;
      viol_set = out_q && !out_d && !win_done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q    <= 1'b0;
         tick_cnt <= '0;
      end else begin
         out_q <= out_d;
         if (!out_q)                        tick_cnt <= '0;
         else if (tick && tick_cnt != MAXC) tick_cnt <= tick_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dram_sleep_guard.sv
module dram_sleep_guard #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int CODE_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              cfg_wr,
   input  logic [CODE_W+1:0] cfg_wdata,
   output logic [CODE_W+1:0] cfg_rdata,
   output logic              sleep_out
);
   import dsg_pkg::*;
   localparam int MAXT  = max_ticks(CODE_W);
   localparam int CNT_W = $clog2(MAXT + 1);

   generate
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("TICKS_PER_SEC must be at least 1");
      end
      if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
         $error("CODE_W must be between 1 and 4");
      end
   endgenerate

   logic              tick;
   logic [CODE_W-1:0] code_q;
   logic              stretch_q;
   logic              viol_q;
   logic              viol_set;
   logic              win_done;
   logic [CNT_W-1:0]  tick_cnt;

   dsg_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   dsg_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .wdata    (cfg_wdata),
      .viol_set (viol_set),
      .code_q   (code_q),
      .stretch_q(stretch_q),
      .viol_q   (viol_q)
   );

   dsg_window #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (sleep_req),
      .tick    (tick),
      .code    (code_q),
      .stretch (stretch_q),
      .out_q   (sleep_out),
      .win_done(win_done),
      .viol_set(viol_set),
      .tick_cnt(tick_cnt)
   );

   assign cfg_rdata = {viol_q, stretch_q, code_q};
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
   parameter int CODE_W = 2,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_req,
   input logic              sleep_out,
   input logic              cfg_wr,
   input logic [CODE_W+1:0] cfg_wdata,
   input logic [CODE_W-1:0] code,
   input logic              stretch,
   input logic              viol,
   input logic              win_done,
   input logic [CNT_W-1:0]  tick_cnt
);
   localparam logic [CNT_W-1:0] MAXC = CNT_W'((1 << CODE_W) + 1);

   // R2: reset clears output and all register fields
   a_r2_reset_state: assert property (@(posedge clk)
      !rst_n |=> (code == '0 && !stretch && !viol && !sleep_out));

   // R1: a request while idle asserts the output next cycle
   a_r1_assert_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_out && sleep_req) |=> sleep_out);

   // R5: stretched output is held while the window is open
   a_r5_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_out && stretch && !win_done) |=> sleep_out);

   // R6: once the window is done, a released request drops the output
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_out && win_done && !sleep_req) |=> !sleep_out);

   // R7: an early end of an assertion raises the flag
   a_r7_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sleep_out) && !$past(win_done)) |-> viol);

   // R8: the flag only clears through a write-one
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !(cfg_wr && cfg_wdata[CODE_W+1])) |=> viol);

   // R4: a new assertion starts its window at zero ticks
   a_r4_window_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_out) |-> (tick_cnt == '0));

   // R4: tick count never passes the longest window
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt <= MAXC);
endmodule

bind dram_sleep_guard dsg_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sleep_req(sleep_req),
   .sleep_out(sleep_out),
   .cfg_wr   (cfg_wr),
   .cfg_wdata(cfg_wdata),
   .code     (code_q),
   .stretch  (stretch_q),
   .viol     (viol_q),
   .win_done (win_done),
   .tick_cnt (tick_cnt)
);

// File: tb/dram_sleep_guard_tb.sv
module dram_sleep_guard_tb;
   localparam int T  = 8;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [CW+1:0] cfg_wdata = '0;
   logic [CW+1:0] cfg_rdata;
   logic          sleep_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dram_sleep_guard #(.TICKS_PER_SEC(T), .CODE_W(CW)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_req(sleep_req),
      .cfg_wr   (cfg_wr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .sleep_out(sleep_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [1:0] code, input bit stretch, input bit clr);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = {clr, stretch, code};
      @(negedge clk);
      cfg_wr    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Raise the request for len cycles and count output-high cycles
   task automatic pulse(input int len, output int dur);
      @(negedge clk);
      sleep_req = 1'b1;
      dur = 0;
      for (int i = 1; i < 2000; i++) begin
         @(negedge clk);
         if (!sleep_out) break;
         dur++;
         if (i == len) sleep_req = 1'b0;
      end
      sleep_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      check(cfg_rdata == 4'b0000, "R2 reset register", int'(cfg_rdata), 0);
      check(sleep_out == 1'b0, "R2 reset output", int'(sleep_out), 0);
   endtask

   task automatic t_no_stretch_short();
      int d;
      write_cfg(2'b00, 1'b0, 1'b0);
      pulse(1, d);
      check(d == 1, "R1 one-cycle follow", d, 1);
      check(cfg_rdata[3] == 1'b1, "R7 early end flagged", int'(cfg_rdata[3]), 1);
      write_cfg(2'b00, 1'b0, 1'b0);
      check(cfg_rdata[3] == 1'b1, "R8 write zero keeps flag", int'(cfg_rdata[3]), 1);
      write_cfg(2'b00, 1'b0, 1'b1);
      check(cfg_rdata[3] == 1'b0, "R8 write one clears flag", int'(cfg_rdata[3]), 0);
   endtask

   task automatic t_no_stretch_long();
      int d;
      write_cfg(2'b11, 1'b0, 1'b1);
      pulse(2 * T + 2, d);
      check(d == 2 * T + 2, "R6 follow long request", d, 2 * T + 2);
      check(cfg_rdata[3] == 1'b0, "R7 no flag when window met", int'(cfg_rdata[3]), 0);
   endtask

   task automatic t_windows();
      int d;
      for (int c = 0; c < 4; c++) begin
         int n  = 5 - c;
         int lo = (n - 1) * T + 2;
         int hi = n * T + 1;
         write_cfg(2'(c), 1'b1, 1'b1);
         check(cfg_rdata == {2'b01, 2'(c)}, "R3 readback", int'(cfg_rdata), 4 + c);
         pulse(1, d);
         check(d >= lo && d <= hi, "R4/R5 stretched width", d, lo);
         check(cfg_rdata[3] == 1'b0, "R5 no flag when held", int'(cfg_rdata[3]), 0);
      end
   endtask

   task automatic t_stretch_long();
      int d;
      write_cfg(2'b10, 1'b1, 1'b1);
      pulse(3 * T + 5, d);
      check(d == 3 * T + 5, "R6 release after window", d, 3 * T + 5);
   endtask

   task automatic t_sticky();
      int d;
      write_cfg(2'b01, 1'b0, 1'b1);
      pulse(2, d);
      check(cfg_rdata[3] == 1'b1, "R7 flag set", int'(cfg_rdata[3]), 1);
      write_cfg(2'b11, 1'b0, 1'b0);
      pulse(2 * T + 2, d);
      check(cfg_rdata[3] == 1'b1, "R7 flag sticky", int'(cfg_rdata[3]), 1);
   endtask

   task automatic t_reset_restore();
      write_cfg(2'b11, 1'b1, 1'b0);
      check(cfg_rdata == 4'b1111, "R3 fields written", int'(cfg_rdata), 15);
      do_reset();
      @(negedge clk);
      check(cfg_rdata == 4'b0000, "R2 reset restores defaults", int'(cfg_rdata), 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_no_stretch_short();
      t_no_stretch_long();
      t_windows();
      t_stretch_long();
      t_sticky();
      t_reset_restore();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         finish_run();
      end
   end
endmodule